// File: doc/BRIEF.md
# Word/Dword I/O Window Decoder

This block decodes slave I/O accesses aimed at a 32-byte window whose start is set by a programmed base address. Each accepted access becomes an internal resource index, a write strobe with lane-aligned write data, and read data steered back onto the correct bus lanes. The decoder runs in one of two access modes. In word mode every resource is 16 bits wide, and resources sit 2 bytes apart. In dword mode every resource is 32 bits wide, and resources sit 4 bytes apart.

After a hard reset the block is in word mode. It moves to dword mode by itself the first time a full 32-bit write lands on window offset 10h, and only a hard reset brings it back to word mode. The decode is combinational. The mode flag is the only state, and it changes on the clock edge that ends the switching write. An access whose width does not suit the current mode is refused: a refused write reaches no resource, and a refused read returns zero. The resources themselves sit outside the block. They receive the index, the write strobe and the write data, and they return the selected resource's value on `res_rdata`.

Top module: `io_window_decoder`

## Requirements
- R1: After hard reset (`rst` high at a clock edge) `dword_mode` is 0, so the block starts in word mode.
- R2: `hit` is high exactly when `io_en` and `acc_valid` are both high and `acc_addr[ADDR_W-1:5]` equals `base_addr[ADDR_W-1:5]`. The low 5 bits of `base_addr` are ignored.
- R3: In word mode, a hit is accepted (`acc_ok` = 1) when `acc_addr[0]` = 0 and `acc_be` is 4'b0011 with `acc_addr[1]` = 0, or 4'b1100 with `acc_addr[1]` = 1. The index is then offset[4:1], a value from 0 to 15.
- R4: An accepted word-mode write raises `res_we`. `res_wdata` carries the 16-bit write lane chosen by `acc_addr[1]` (bits 15:0 for 0, bits 31:16 for 1), zero-extended.
- R5: An accepted word-mode read returns the low 16 bits of `res_rdata` on lane `acc_addr[1]` of `bus_rdata`, and the other lane reads zero.
- R6: In word mode, any hit other than those in R3 and R7 gives `acc_ok` = 0, `res_we` = 0, `res_idx` = 0 and `bus_rdata` = 0.
- R7: In word mode, a hit write with `acc_be` = 4'b1111 at offset 10h is accepted as resource 4 with the full 32-bit data, and `dword_mode` reads 1 from the next cycle.
- R8: No other access sets `dword_mode`. This covers a read at 10h, a partial write at 10h, a full write at any other offset, and a full write at 10h that misses.
- R9: In dword mode, a hit is accepted only when `acc_addr[1:0]` = 0 and `acc_be` = 4'b1111. The index is offset[4:2], a value from 0 to 7, and write and read data pass through as full 32-bit words.
- R10: In dword mode, a hit that is not accepted under R9 writes nothing and reads zero.
- R11: Once set, `dword_mode` stays 1 whatever accesses follow, until the next hard reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| io_en | input | 1 | I/O space enable |
| base_addr | input | ADDR_W | Window base address (low 5 bits ignored) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_be | input | 4 | Active-high byte enables |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Bus write data |
| res_rdata | input | 32 | Value of the resource selected by `res_idx` |
| hit | output | 1 | Access falls in the window |
| acc_ok | output | 1 | Access accepted under the current mode |
| res_idx | output | 4 | Resource index (0 when not accepted) |
| dword_mode | output | 1 | 0 = word mode, 1 = dword mode |
| res_we | output | 1 | Write strobe toward the resources |
| res_wdata | output | 32 | Lane-aligned resource write data |
| bus_rdata | output | 32 | Read data steered onto the bus lanes |

## Verification
Word-mode accesses use both halves of a dword, the first and last resource, and the two write lanes with distinct data. These show whether the index shift and the lane choice are right. Addresses just below and just above the window, a cleared enable, and a base with nonzero low bits separate a correct window compare from one that is off by a bit. Near-miss writes around offset 10h separate the single qualifying switch from anything close to it: a read there, a partial write there, a full write at 14h, and a full write there while disabled. Dword-mode accesses of every wrong width, followed by a long idle run and a hard reset, confirm that the mode cannot be left except through reset. Every write goes into a register array in the bench and is read back later, so a wrong index or lane shows up as a data mismatch.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    localparam int WIN_BITS  = 5;
    localparam int IDX_W     = 4;
    localparam int DATA_W    = 32;
    localparam int HALF_W    = DATA_W / 2;
    localparam int BE_W      = DATA_W / 8;
    localparam logic [WIN_BITS-1:0] SWITCH_OFS = 5'h10;
    localparam logic [BE_W-1:0]     BE_FULL    = '1;

    typedef enum logic {
        MODE_WORD  = 1'b0,
        MODE_DWORD = 1'b1
    } iomode_e;

    typedef struct packed {
        logic                hit;
        logic [WIN_BITS-1:0] ofs;
    } win_t;

    typedef struct packed {
        logic             ok;
        logic             sw;
        logic             wide;
        logic [IDX_W-1:0] idx;
    } acc_t;

    // Byte enables that a 16-bit access to the given half must carry.
    function automatic logic [BE_W-1:0] half_be(input logic upper);
        return upper ? 4'b1100 : 4'b0011;
    endfunction

endpackage

// File: rtl/iowin_match.sv
module iowin_match
    import iowin_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              io_en,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] acc_addr,
    output win_t              win
);
    localparam int TAG_LO = WIN_BITS;

    logic tag_eq;

    always_comb begin
        tag_eq  = (acc_addr[ADDR_W-1:TAG_LO] == base_addr[ADDR_W-1:TAG_LO]);
        win.hit = io_en && acc_valid && tag_eq;
        win.ofs = acc_addr[WIN_BITS-1:0];
    end

endmodule

// File: rtl/iowin_width_chk.sv
module iowin_width_chk
    import iowin_pkg::*;
(
    input  win_t            win,
    input  logic [BE_W-1:0] acc_be,
    input  logic            acc_wr,
    input  iomode_e         mode,
    output acc_t            acc
);
    logic half_fit;
    logic full_fit;
    logic sw;
    logic wide;
    logic ok;

    always_comb begin
        half_fit = (win.ofs[0] == 1'b0) && (acc_be == half_be(win.ofs[1]));
        full_fit = (win.ofs[1:0] == 2'b00) && (acc_be == BE_FULL);
        sw       = win.hit && acc_wr && (mode == MODE_WORD)
                   && (win.ofs == SWITCH_OFS) && (acc_be == BE_FULL);
        wide     = (mode == MODE_DWORD) || sw;
        ok       = win.hit && (wide ? full_fit : half_fit);

        acc.ok   = ok;
        acc.sw   = sw;
        acc.wide = wide;
        if (!ok)
            acc.idx = '0;
        else if (wide)
            acc.idx = {1'b0, win.ofs[WIN_BITS-1:2]};
        else
            acc.idx = win.ofs[WIN_BITS-1:1];
    end

endmodule

// File: rtl/iowin_mode_reg.sv
module iowin_mode_reg
    import iowin_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  acc_t    acc,
    output iomode_e mode
);
    always_ff @(posedge clk) begin
        if (rst)
            mode <= MODE_WORD;
        else if (acc.sw)
            mode <= MODE_DWORD;
    end

endmodule

// File: rtl/iowin_lanes.sv
module iowin_lanes
    import iowin_pkg::*;
(
    input  acc_t              acc,
    input  logic              upper,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] res_rdata,
    output logic              res_we,
    output logic [DATA_W-1:0] res_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic             rd_take;
    logic [HALF_W-1:0] wr_half;

    always_comb begin
        res_we  = acc.ok && acc_wr;
        rd_take = acc.ok && !acc_wr;
        wr_half = upper ? acc_wdata[DATA_W-1:HALF_W] : acc_wdata[HALF_W-1:0];

        if (!res_we)
            res_wdata = '0;
        else if (acc.wide)
            res_wdata = acc_wdata;
        else
            res_wdata = {{HALF_W{1'b0}}, wr_half};

        if (!rd_take)
            bus_rdata = '0;
        else if (acc.wide)
            bus_rdata = res_rdata;
        else if (upper)
            bus_rdata = {res_rdata[HALF_W-1:0], {HALF_W{1'b0}}};
        else
            bus_rdata = {{HALF_W{1'b0}}, res_rdata[HALF_W-1:0]};
    end

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
    import iowin_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [3:0]        acc_be,
    input  logic              acc_wr,
    input  logic [31:0]       acc_wdata,
    input  logic [31:0]       res_rdata,
    output logic              hit,
    output logic              acc_ok,
    output logic [3:0]        res_idx,
    output logic              dword_mode,
    output logic              res_we,
    output logic [31:0]       res_wdata,
    output logic [31:0]       bus_rdata
);
    win_t    win;
    acc_t    acc;
    iomode_e mode;

    iowin_match #(.ADDR_W(ADDR_W)) u_match (
        .io_en     (io_en),
        .acc_valid (acc_valid),
        .base_addr (base_addr),
        .acc_addr  (acc_addr),
        .win       (win)
    );

    iowin_width_chk u_width (
        .win    (win),
        .acc_be (acc_be),
        .acc_wr (acc_wr),
        .mode   (mode),
        .acc    (acc)
    );

    iowin_mode_reg u_mode (
        .clk  (clk),
        .rst  (rst),
        .acc  (acc),
        .mode (mode)
    );

    iowin_lanes u_lanes (
        .acc       (acc),
        .upper     (win.ofs[1]),
        .acc_wr    (acc_wr),
        .acc_wdata (acc_wdata),
        .res_rdata (res_rdata),
        .res_we    (res_we),
        .res_wdata (res_wdata),
        .bus_rdata (bus_rdata)
    );

    assign hit        = win.hit;
    assign acc_ok     = acc.ok;
    assign res_idx    = acc.idx;
    assign dword_mode = (mode == MODE_DWORD);

endmodule

// File: rtl/io_window_decoder_chk.sv
module io_window_decoder_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              io_en,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [3:0]        acc_be,
    input logic              acc_wr,
    input logic              hit,
    input logic              acc_ok,
    input logic              dword_mode,
    input logic              res_we,
    input logic [31:0]       bus_rdata
);
    // R2
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (io_en && acc_valid));

    // R6
    miss_is_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (!res_we && bus_rdata == 32'h0));

    // R10
    write_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (acc_ok && acc_wr));

    // R9
    dword_accept_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (dword_mode && acc_ok) |-> (acc_be == 4'hF && acc_addr[1:0] == 2'b00));

    // R11
    mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        dword_mode |=> dword_mode);

    // R7
    mode_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dword_mode) |-> $past(hit && acc_wr && acc_be == 4'hF && acc_addr[4:0] == 5'h10));

endmodule

bind io_window_decoder io_window_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_en      (io_en),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_be     (acc_be),
    .acc_wr     (acc_wr),
    .hit        (hit),
    .acc_ok     (acc_ok),
    .dword_mode (dword_mode),
    .res_we     (res_we),
    .bus_rdata  (bus_rdata)
);

// File: tb/io_window_decoder_test.sv
`timescale 1ns/1ps
module io_window_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_en = 1'b0;
    logic [15:0] base_addr = 16'h0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = 16'h0;
    logic [3:0]  acc_be = 4'h0;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_wdata = 32'h0;
    logic [31:0] res_rdata;
    logic        hit, acc_ok, dword_mode, res_we;
    logic [3:0]  res_idx;
    logic [31:0] res_wdata, bus_rdata;

    int total = 0;
    int bad   = 0;

    // register array standing in for the resources
    logic [31:0] regs [16];
    // reference model state
    bit          m_dw;
    logic [31:0] m_regs [16];

    always #2.5 clk = ~clk;

    io_window_decoder #(.ADDR_W(16)) uut (
        .clk(clk), .rst(rst), .io_en(io_en), .base_addr(base_addr),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_be(acc_be),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .res_rdata(res_rdata),
        .hit(hit), .acc_ok(acc_ok), .res_idx(res_idx), .dword_mode(dword_mode),
        .res_we(res_we), .res_wdata(res_wdata), .bus_rdata(bus_rdata)
    );

    assign res_rdata = regs[res_idx];

    always @(posedge clk) begin
        if (res_we) regs[res_idx] <= res_wdata;
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One access cycle: drive at negedge, compare against the model, advance the model at posedge.
    task automatic step(input string tag, input bit en, input bit vld,
                        input logic [15:0] a, input logic [3:0] be,
                        input bit wr, input logic [31:0] wd);
        bit          e_hit, e_sw, e_wide, e_fit, e_ok;
        logic [4:0]  o;
        logic [3:0]  e_idx;
        logic [31:0] e_wd, e_rd, src;
        @(negedge clk);
        io_en = en; acc_valid = vld; acc_addr = a; acc_be = be; acc_wr = wr; acc_wdata = wd;
        #1;
        o      = a[4:0];
        e_hit  = en && vld && (a[15:5] == base_addr[15:5]);
        e_sw   = e_hit && wr && !m_dw && be == 4'hF && o == 5'h10;
        e_wide = m_dw || e_sw;
        if (e_wide) e_fit = (o[1:0] == 2'b00) && be == 4'hF;
        else        e_fit = (o[0] == 1'b0) && be == (o[1] ? 4'b1100 : 4'b0011);
        e_ok   = e_hit && e_fit;
        e_idx  = !e_ok ? 4'd0 : (e_wide ? 4'(o >> 2) : 4'(o >> 1));
        e_wd   = 32'h0;
        e_rd   = 32'h0;
        if (e_ok && wr) e_wd = e_wide ? wd : (o[1] ? {16'h0, wd[31:16]} : {16'h0, wd[15:0]});
        if (e_ok && !wr) begin
            src  = m_regs[e_idx];
            e_rd = e_wide ? src : (o[1] ? {src[15:0], 16'h0} : {16'h0, src[15:0]});
        end
        check(tag, "hit",        32'(hit),        32'(e_hit));
        check(tag, "acc_ok",     32'(acc_ok),     32'(e_ok));
        check(tag, "res_idx",    32'(res_idx),    32'(e_idx));
        check(tag, "dword_mode", 32'(dword_mode), 32'(m_dw));
        check(tag, "res_we",     32'(res_we),     32'(e_ok && wr));
        check(tag, "res_wdata",  res_wdata,       e_wd);
        check(tag, "bus_rdata",  bus_rdata,       e_rd);
        @(posedge clk);
        if (e_ok && wr) m_regs[e_idx] = e_wd;
        if (e_sw) m_dw = 1'b1;
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b1, 1'b0, 16'h0, 4'h0, 1'b0, 32'h0);
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst = 1'b1;
        acc_valid = 1'b0;
        repeat (2) @(posedge clk);
        m_dw = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            regs[i]   = 32'hC0DE_0000 + 32'(i * 32'h0101_0101);
            m_regs[i] = regs[i];
        end
        m_dw = 1'b0;
        base_addr = 16'h0317;   // low bits must be ignored
        hard_reset();

        // R1 reset state
        idle("R1");

        // R3 word index, both halves and last resource
        step("R3", 1, 1, 16'h0304, 4'b0011, 0, 32'h0);
        step("R3", 1, 1, 16'h0306, 4'b1100, 0, 32'h0);
        step("R3", 1, 1, 16'h031E, 4'b1100, 0, 32'h0);
        step("R3", 1, 1, 16'h0300, 4'b0011, 0, 32'h0);

        // R4 word writes on both lanes
        step("R4", 1, 1, 16'h0306, 4'b1100, 1, 32'h1234_5678);
        step("R4", 1, 1, 16'h0300, 4'b0011, 1, 32'h9ABC_DEF0);
        step("R4", 1, 1, 16'h031C, 4'b0011, 1, 32'h0000_4321);

        // R5 word reads back
        step("R5", 1, 1, 16'h0306, 4'b1100, 0, 32'h0);
        step("R5", 1, 1, 16'h0300, 4'b0011, 0, 32'h0);
        step("R5", 1, 1, 16'h031C, 4'b0011, 0, 32'h0);

        // R2 window edges and enable
        step("R2", 1, 1, 16'h0320, 4'b0011, 0, 32'h0);
        step("R2", 1, 1, 16'h02FE, 4'b1100, 0, 32'h0);
        step("R2", 0, 1, 16'h0300, 4'b0011, 1, 32'hFFFF_FFFF);
        step("R2", 1, 1, 16'h031F, 4'b1000, 0, 32'h0);

        // R6 mismatched word-mode accesses
        step("R6", 1, 1, 16'h0302, 4'b0011, 1, 32'hDEAD_BEEF);
        step("R6", 1, 1, 16'h0301, 4'b0110, 0, 32'h0);
        step("R6", 1, 1, 16'h0300, 4'hF,    0, 32'h0);
        step("R6", 1, 1, 16'h0300, 4'b0001, 1, 32'hDEAD_BEEF);
        step("R6", 1, 1, 16'h0302, 4'b1100, 0, 32'h0);

        // R8 near misses around the switching write
        step("R8", 1, 1, 16'h0314, 4'hF,    1, 32'h5555_5555);
        step("R8", 1, 1, 16'h0310, 4'hF,    0, 32'h0);
        step("R8", 1, 1, 16'h0310, 4'b0011, 1, 32'h0000_7777);
        step("R8", 0, 1, 16'h0310, 4'hF,    1, 32'h6666_6666);
        step("R8", 1, 1, 16'h0330, 4'hF,    1, 32'h6666_6666);
        idle("R8");

        // R7 switching write
        step("R7", 1, 1, 16'h0310, 4'hF, 1, 32'hA1B2_C3D4);
        idle("R7");

        // R9 dword accesses
        step("R9", 1, 1, 16'h031C, 4'hF, 1, 32'h0BAD_F00D);
        step("R9", 1, 1, 16'h031C, 4'hF, 0, 32'h0);
        step("R9", 1, 1, 16'h0310, 4'hF, 0, 32'h0);
        step("R9", 1, 1, 16'h0300, 4'hF, 0, 32'h0);
        step("R9", 1, 1, 16'h0304, 4'hF, 1, 32'h1357_9BDF);
        step("R9", 1, 1, 16'h0304, 4'hF, 0, 32'h0);

        // R10 word-sized accesses in dword mode
        step("R10", 1, 1, 16'h0302, 4'hF,    1, 32'hFFFF_0000);
        step("R10", 1, 1, 16'h0300, 4'b0011, 1, 32'hFFFF_0000);
        step("R10", 1, 1, 16'h0306, 4'b1100, 0, 32'h0);
        step("R10", 1, 1, 16'h0304, 4'b0011, 0, 32'h0);
        step("R10", 1, 1, 16'h0300, 4'hF,    0, 32'h0);

        // R11 mode holds across traffic and idle time, then clears on reset
        step("R11", 1, 1, 16'h0310, 4'hF, 1, 32'h0);
        for (int k = 0; k < 20; k++) idle("R11");
        hard_reset();
        idle("R11");
        step("R11", 1, 1, 16'h0304, 4'b0011, 0, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule